// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous request port inside the chip and an external 8K x 8 static RAM that has no clock of its own. A requester presents a 13-bit address, a read/write flag and an 8-bit byte with a one-cycle valid strobe while the controller is idle. The controller then runs the RAM pins through a fixed sequence: address and both selects first, then the strobe, then a hold cycle. For a write it also enables its own drivers onto the shared data bus. A read ends with a captured byte, and every cycle ends with a one-cycle done pulse.

Each RAM timing limit is a nanosecond parameter. The controller converts it to whole clock cycles by rounding up over the clock period. A write is timed by the overlap of the selects and the write strobe. The controller always ends that overlap by raising the write strobe while the selects stay asserted, so data setup and hold are counted from that rising edge. The data-bus enable and the RAM output enable are never on together. After a read, the bus is left floating long enough for the RAM outputs to turn off before the controller drives it again.

Top module: `sram_ctl`

## Requirements
- R1: During reset and on the first cycle after it, busy and done are 0, the low-active select is 1, the high-active select is 0, output enable and write strobe are high (inactive) and the data-bus enable is 0.
- R2: Whenever the controller is not busy, both selects are in the deselected state (low-active select 1, high-active select 0).
- R3: In a write, the write strobe is low for exactly ceil(12 ns / Tclk) cycles (3 at 4 ns). It is low only while both selects are asserted and output enable is high.
- R4: The data-bus enable turns on no earlier than the cycle in which the write strobe falls. The driven byte equals the requested write data and stays stable. The byte is still driven, with both selects asserted, for at least one cycle after the write strobe rises.
- R5: In a read, output enable is low with both selects asserted and the write strobe high for ceil(15 ns / Tclk) cycles (4 at 4 ns). The byte on the data input is captured on the edge that ends that window, and done is high for exactly that one following cycle together with the byte.
- R6: The data-bus enable and a low output enable never occur in the same cycle. The bus is not driven in the cycle right after output enable rises.
- R7: busy rises on the edge that accepts a request and stays high until the controller is idle again. A request presented while busy is ignored.
- R8: A write raises done for one cycle once the hold cycle ends. The selected part of a write lasts at least ceil(15 ns / Tclk) cycles.
- R9: The RAM address stays unchanged for as long as the selects are asserted.
- R10: A byte written to any address, including the lowest (0) and highest (8191), is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | High for the whole of a cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| ram_addr | output | 13 | RAM address pins |
| ram_sel_n | output | 1 | Low-active RAM select |
| ram_sel | output | 1 | High-active RAM select |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq_out | output | 8 | Byte to drive onto the data bus |
| ram_dq_oe | output | 1 | Enable of the controller's data-bus drivers |
| ram_dq_in | input | 8 | Byte read from the data bus |

## Verification
A wrong state or a wrong cycle count shows up at the pins within one cycle. Examples are a strobe pulse one cycle short or long, output enable left low while the drivers turn on, and the address moving under an asserted select. A read window that is too short captures a byte the RAM has not yet driven, so the wrong value appears on rd_data when done pulses. A write that is lost or misdirected stays hidden until the address is read back, so every write is followed later by a read of the same address.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW      = 13,
  parameter int DW      = 8,
  parameter int CLK_NS  = 4,
  parameter int T_WP_NS = 12,
  parameter int T_DS_NS = 10,
  parameter int T_WC_NS = 15,
  parameter int T_AA_NS = 15,
  parameter int T_OE_NS = 10,
  parameter int T_OZ_NS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_sel_n,
  output logic          ram_sel,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);
  localparam int WP_RAW  = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int DS_RAW  = (T_DS_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC_RAW  = (T_WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int AA_RAW  = (T_AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE_RAW  = (T_OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int OZ_RAW  = (T_OZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_CYC  = (WP_RAW > DS_RAW) ? ((WP_RAW > 0) ? WP_RAW : 1) : ((DS_RAW > 0) ? DS_RAW : 1);
  localparam int HLD_CYC = (WC_RAW > WP_CYC + 2) ? (WC_RAW - WP_CYC - 1) : 1;
  localparam int ACC_CYC = (AA_RAW > OE_RAW) ? ((AA_RAW > 0) ? AA_RAW : 1) : ((OE_RAW > 0) ? OE_RAW : 1);
  localparam int FLT_CYC = (OZ_RAW > 0) ? OZ_RAW : 1;
  localparam int CW      = $clog2(WP_CYC + HLD_CYC + ACC_CYC + FLT_CYC + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WPUL, S_WHLD, S_RACC, S_GAP
  } state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdat_q;
  logic            last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          wdat_q <= req_wdata;
          if (req_write) begin
            st  <= S_WSET;
            cnt <= '0;
          end else begin
            st  <= S_RACC;
            cnt <= CW'(ACC_CYC - 1);
          end
        end
        S_WSET: begin
          st  <= S_WPUL;
          cnt <= CW'(WP_CYC - 1);
        end
        S_WPUL: if (last) begin
          st  <= S_WHLD;
          cnt <= CW'(HLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WHLD: if (last) begin
          st   <= S_GAP;
          cnt  <= '0;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        S_RACC: if (last) begin
          st      <= S_GAP;
          cnt     <= CW'(FLT_CYC - 1);
          rd_data <= ram_dq_in;
          done    <= 1'b1;
        end else cnt <= cnt - 1'b1;
        S_GAP: if (last) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic selected;
  assign selected   = (st == S_WSET) || (st == S_WPUL) || (st == S_WHLD) || (st == S_RACC);
  assign busy       = (st != S_IDLE);
  assign ram_sel_n  = ~selected;
  assign ram_sel    = selected;
  assign ram_oe_n   = ~(st == S_RACC);
  assign ram_we_n   = ~(st == S_WPUL);
  assign ram_dq_oe  = (st == S_WPUL) || (st == S_WHLD);
  assign ram_dq_out = wdat_q;
  assign ram_addr   = addr_q;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW      = 13,
  parameter int DW      = 8,
  parameter int CLK_NS  = 4,
  parameter int T_WP_NS = 12,
  parameter int T_DS_NS = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] ram_addr,
  input logic          ram_sel_n,
  input logic          ram_sel,
  input logic          ram_oe_n,
  input logic          ram_we_n,
  input logic [DW-1:0] ram_dq_out,
  input logic          ram_dq_oe
);
  localparam int WPR = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int DSR = (T_DS_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP  = (WPR > DSR) ? ((WPR > 0) ? WPR : 1) : ((DSR > 0) ? DSR : 1);

  int we_lo;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) we_lo <= 0;
    else if (!ram_we_n) we_lo <= we_lo + 1;
    else we_lo <= 0;

  a_r1_reset_state: assert property (@(posedge clk) !rst_n |=>
    (ram_sel_n && !ram_sel && ram_oe_n && ram_we_n && !ram_dq_oe && !busy && !done));
  a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ram_sel_n && !ram_sel));
  a_r3_we_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_sel_n && ram_sel && ram_oe_n));
  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_lo == WP));
  a_r4_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> !ram_we_n);
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out));
  a_r4_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (ram_dq_oe && !ram_sel_n && ram_sel));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_dq_oe && !ram_oe_n));
  a_r6_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_oe_n) |-> !ram_dq_oe);
  a_r7_select_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel_n |-> busy);
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_sel_n && $past(!ram_sel_n)) |-> $stable(ram_addr));
endmodule

bind sram_ctl sram_ctl_chk #(
  .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS), .T_DS_NS(T_DS_NS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ram_addr(ram_addr),
  .ram_sel_n(ram_sel_n), .ram_sel(ram_sel), .ram_oe_n(ram_oe_n),
  .ram_we_n(ram_we_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe)
);

// File: tb/test_sram_ctl.sv
module test_sram_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done;
  logic [7:0]  rd_data;
  logic [12:0] ram_addr;
  logic        ram_sel_n, ram_sel, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [7:0]  ram_dq_out;
  logic [7:0]  ram_dq_in = 8'hEE;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sram_ctl i_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .ram_addr(ram_addr), .ram_sel_n(ram_sel_n),
    .ram_sel(ram_sel), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // RAM model: commits on the end of select/strobe overlap; read data valid 4 cycles after output enable
  logic [7:0]  mem [logic [12:0]];
  logic        wr_pend = 1'b0;
  logic [12:0] wr_a;
  logic [7:0]  wr_d;
  int          oe_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!ram_sel_n && ram_sel && !ram_we_n) begin
      wr_pend = 1'b1; wr_a = ram_addr; wr_d = ram_dq_out;
    end else if (wr_pend) begin
      mem[wr_a] = wr_d; wr_pend = 1'b0;
    end
    if (!ram_sel_n && ram_sel && !ram_oe_n && ram_we_n) oe_cnt++;
    else oe_cnt = 0;
    if (oe_cnt >= 4) ram_dq_in = mem.exists(ram_addr) ? mem[ram_addr] : 8'h00;
    else ram_dq_in = 8'hEE;
    if (rst_n && ram_dq_oe && !ram_oe_n) chk(0, "R6 contention", 1, 0);
  end

  task automatic start(input bit w, input [12:0] a, input [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input [12:0] a, input [7:0] d);
    int we_lo = 0, done_at = 0, idle_at = 0, drv_early = 0, drv_bad = 0, dones = 0;
    start(1'b1, a, d);
    for (int n = 1; n <= 16; n++) begin
      if (n > 1) @(negedge clk);
      if (!ram_we_n) we_lo++;
      if (ram_dq_oe && we_lo == 0) drv_early++;
      if (ram_dq_oe && ram_dq_out != d) drv_bad++;
      if (done) begin dones++; if (done_at == 0) done_at = n; end
      if (!busy && idle_at == 0) idle_at = n;
      if (!busy && (!ram_sel_n || ram_sel)) chk(0, "R2 idle select", 1, 0);
    end
    chk(we_lo == 3, "R3 strobe width", we_lo, 3);
    chk(drv_early == 0 && drv_bad == 0, "R4 drive window/data", drv_early + drv_bad, 0);
    chk(done_at == 6 && dones == 1, "R8 write done cycle", done_at, 6);
    chk(idle_at == 7, "R7 busy span write", idle_at, 7);
    chk(mem.exists(a) && mem[a] == d, "R10 stored byte", mem.exists(a) ? int'(mem[a]) : -1, d);
  endtask

  task automatic do_read(input [12:0] a, input [7:0] exp);
    int oe_lo = 0, done_at = 0, idle_at = 0, we_bad = 0;
    start(1'b0, a, 8'h00);
    for (int n = 1; n <= 16; n++) begin
      if (n > 1) @(negedge clk);
      if (!ram_oe_n && !ram_sel_n && ram_sel) oe_lo++;
      if (!ram_oe_n && !ram_we_n) we_bad++;
      if (done && done_at == 0) begin
        done_at = n;
        chk(rd_data == exp, "R5 captured byte", rd_data, exp);
      end
      if (!busy && idle_at == 0) idle_at = n;
    end
    chk(oe_lo == 4 && we_bad == 0, "R5 read window", oe_lo, 4);
    chk(done_at == 5, "R5 done cycle", done_at, 5);
    chk(idle_at == 7, "R7 busy span read", idle_at, 7);
  endtask

  task automatic t_reset;
    #1;
    chk(!busy && !done && ram_sel_n && !ram_sel && ram_oe_n && ram_we_n && !ram_dq_oe,
        "R1 reset outputs", {busy, done, ram_sel_n, ram_sel, ram_oe_n, ram_we_n, ram_dq_oe}, 7'b0010110);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && ram_sel_n && !ram_sel && !ram_dq_oe, "R1 after release", busy, 0);
  endtask

  task automatic t_ignore_busy;
    int dones = 0;
    start(1'b1, 13'h0040, 8'hC3);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0041; req_wdata = 8'h5A;
    for (int n = 2; n <= 16; n++) begin
      @(negedge clk);
      if (n == 4) req_valid = 1'b0;
      if (!ram_sel_n) chk(ram_addr == 13'h0040, "R9 address held", ram_addr, 13'h0040);
      if (done) dones++;
    end
    chk(dones == 1, "R7 single cycle run", dones, 1);
    do_read(13'h0041, 8'h11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    do_write(13'h0000, 8'hA5);
    do_write(13'h1FFF, 8'h3C);
    do_write(13'h0041, 8'h11);
    do_read(13'h0000, 8'hA5);
    do_read(13'h1FFF, 8'h3C);
    do_write(13'h0123, 8'hFF);
    do_read(13'h0123, 8'hFF);
    do_write(13'h0123, 8'h00);
    do_read(13'h0123, 8'h00);
    t_ignore_busy();
    do_read(13'h0040, 8'hC3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule